// File: doc/BRIEF.md
# Three-Counter Performance Monitor

This block counts activity inside a processor: one counter advances with the clock and two programmable counters each follow one line of a wide vector of single-cycle event pulses. Software drives it through a small register file of four words. One is a shared control/status word and the other three are the counters themselves. Each counter can be read and written.

The control word holds several fields. A global run bit gates every counter at once, so counters cannot be started or stopped one by one. An event counter is parked by giving it the idle event code, which never asserts. The control word also holds a divide mode for the cycle counter, per-counter interrupt enables, two self-clearing reset strobes and three sticky wrap flags. A flag is cleared by writing a one to it. A single interrupt output is raised while any flag is set and its enable is on. A control value read earlier can be written back without changing anything, except that it clears the flags it carried.

Top module: `perf_mon`

## Requirements
- R1: After reset all three counters, every control field and the interrupt output are zero.
- R2: While control bit 0 (run) is clear, no counter changes except through a register write or a reset strobe.
- R3: While run is set, event counter 0 adds one on each clock in which evt_in[code0] is high, where code0 is control bits 27:20. Event counter 1 does the same with code1, held in control bits 19:12. Code 0xFF counts every clock.
- R4: Event code 0x20 selects an idle source. A counter set to it never advances, whatever evt_in[32] does.
- R5: While run is set, the cycle counter adds one every clock when control bit 3 is clear. When bit 3 is set it adds one every 2^DIV_LOG2 clocks, driven by a prescaler that starts from zero.
- R6: Writing control with bit 1 set zeroes both event counters. Writing it with bit 2 set zeroes the cycle counter and its prescaler. Both bits always read back as 0.
- R7: Counter addresses are 1 for the cycle counter, 2 for event counter 0 and 3 for event counter 1, with control at address 0. A write loads the counter, so writing zero clears it. If a count falls in the same clock as the write, the written value is kept.
- R8: A counter that wraps from all ones to zero sets its sticky flag on the same edge. The flags are bit 8 for event counter 0, bit 9 for event counter 1 and bit 10 for the cycle counter.
- R9: Writing 1 to a flag bit clears it and writing 0 leaves it set. Writing back a previously read control value changes no field other than the flags it clears.
- R10: The irq output is high in the clock after any flag is set together with its enable, and low otherwise. The enables are bit 4 for event counter 0, bit 5 for event counter 1 and bit 6 for the cycle counter.
- R11: rd_data is registered. It shows the word at rd_addr as it stood at the edge where the address was sampled, and counters narrower than 32 bits are zero-extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 32 | Registered read data |
| evt_in | input | 256 | Event pulse vector indexed by event code |
| irq | output | 1 | Shared overflow interrupt, registered |

## Verification
The bench builds the block with CNT_W = 8 and DIV_LOG2 = 2. With 8-bit counters every wrap can be reached in a few clocks, and with a divide of four several prescaler periods fit in a short run. Each test writes a counter to a chosen value and counts exact edge totals, so every wrap and divide point is checked against arithmetic. A sweep over eight pairs of selector codes, with all other event lines held high, exposes any wrong mux index or field position.

// File: rtl/pmu_pkg.sv
package pmu_pkg;
  localparam int CTRL_W   = 32;
  localparam int CODE_W   = 8;
  localparam int N_EVT    = 1 << CODE_W;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_CYC  = 2'd1;
  localparam logic [1:0] ADDR_EV0  = 2'd2;
  localparam logic [1:0] ADDR_EV1  = 2'd3;

  localparam int B_RUN     = 0;
  localparam int B_CLR_EV  = 1;
  localparam int B_CLR_CYC = 2;
  localparam int B_DIV     = 3;
  localparam int B_IE_LO   = 4;   // ev0, ev1, cyc
  localparam int B_OV_LO   = 8;   // ev0, ev1, cyc
  localparam int SEL1_LO   = 12;
  localparam int SEL0_LO   = 20;

  localparam logic [CODE_W-1:0] CODE_IDLE   = 8'h20;
  localparam logic [CODE_W-1:0] CODE_CYCLES = 8'hFF;
endpackage

// File: rtl/pmu_evt_pick.sv
module pmu_evt_pick
  import pmu_pkg::*;
(
  input  logic [CODE_W-1:0] code,
  input  logic [N_EVT-1:0]  evt_in,
  output logic              hit
);
  always_comb begin
    if (code == CODE_CYCLES)    hit = 1'b1;
    else if (code == CODE_IDLE) hit = 1'b0;
    else                        hit = evt_in[code];
  end
endmodule

// File: rtl/pmu_counter.sv
module pmu_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         inc,
  output logic [W-1:0] value,
  output logic         wrap
);
  // a wrap only counts when the increment is actually taken
  assign wrap = inc && (&value) && !clr && !load;

  always_ff @(posedge clk) begin
    if (rst)       value <= '0;
    else if (clr)  value <= '0;
    else if (load) value <= load_val;
    else if (inc)  value <= value + 1'b1;
  end
endmodule

// File: rtl/perf_mon.sv
module perf_mon
  import pmu_pkg::*;
#(
  parameter int CNT_W    = 32,
  parameter int DIV_LOG2 = 6
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [1:0]          wr_addr,
  input  logic [CTRL_W-1:0]   wr_data,
  input  logic [1:0]          rd_addr,
  output logic [CTRL_W-1:0]   rd_data,
  input  logic [N_EVT-1:0]    evt_in,
  output logic                irq
);
  localparam int N_CNT = 3;
  localparam int I_CYC = 2;

  logic                    run_q, div_q;
  logic [N_CNT-1:0]        ie_q, ov_q, wrap;
  logic [1:0][CODE_W-1:0]  sel_q;
  logic [1:0][CNT_W-1:0]   ev_val;
  logic [CNT_W-1:0]        cyc_val;
  logic [DIV_LOG2-1:0]     pre_q;
  logic                    ctrl_wr, clr_ev, clr_cyc, cyc_inc;
  logic [CTRL_W-1:0]       ctrl_rd;

  assign ctrl_wr = wr_en && (wr_addr == ADDR_CTRL);
  assign clr_ev  = ctrl_wr && wr_data[B_CLR_EV];
  assign clr_cyc = ctrl_wr && wr_data[B_CLR_CYC];

  // event counters
  for (genvar g = 0; g < 2; g++) begin : g_ev
    localparam int         LO     = (g == 0) ? SEL0_LO : SEL1_LO;
    localparam logic [1:0] MY_ADR = (g == 0) ? ADDR_EV0 : ADDR_EV1;
    logic hit;

    always_ff @(posedge clk) begin
      if (rst)          sel_q[g] <= '0;
      else if (ctrl_wr) sel_q[g] <= wr_data[LO +: CODE_W];
    end

    pmu_evt_pick pick_i (
      .code   (sel_q[g]),
      .evt_in (evt_in),
      .hit    (hit)
    );

    pmu_counter #(.W(CNT_W)) cnt_i (
      .clk      (clk),
      .rst      (rst),
      .clr      (clr_ev),
      .load     (wr_en && (wr_addr == MY_ADR)),
      .load_val (wr_data[CNT_W-1:0]),
      .inc      (run_q && hit),
      .value    (ev_val[g]),
      .wrap     (wrap[g])
    );
  end

  // cycle counter with optional prescale
  always_ff @(posedge clk) begin
    if (rst || clr_cyc)     pre_q <= '0;
    else if (run_q && div_q) pre_q <= pre_q + 1'b1;
  end

  assign cyc_inc = run_q && (!div_q || (&pre_q));

  pmu_counter #(.W(CNT_W)) cyc_i (
    .clk      (clk),
    .rst      (rst),
    .clr      (clr_cyc),
    .load     (wr_en && (wr_addr == ADDR_CYC)),
    .load_val (wr_data[CNT_W-1:0]),
    .inc      (cyc_inc),
    .value    (cyc_val),
    .wrap     (wrap[I_CYC])
  );

  // control fields and sticky flags
  always_ff @(posedge clk) begin
    if (rst) begin
      run_q <= 1'b0;
      div_q <= 1'b0;
      ie_q  <= '0;
    end else if (ctrl_wr) begin
      run_q <= wr_data[B_RUN];
      div_q <= wr_data[B_DIV];
      ie_q  <= wr_data[B_IE_LO +: N_CNT];
    end
  end

  for (genvar i = 0; i < N_CNT; i++) begin : g_ov
    always_ff @(posedge clk) begin
      if (rst)                                  ov_q[i] <= 1'b0;
      else if (wrap[i])                         ov_q[i] <= 1'b1;
      else if (ctrl_wr && wr_data[B_OV_LO + i]) ov_q[i] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= |(ov_q & ie_q);
  end

  // read path
  always_comb begin
    ctrl_rd = '0;
    ctrl_rd[B_RUN]               = run_q;
    ctrl_rd[B_DIV]               = div_q;
    ctrl_rd[B_IE_LO +: N_CNT]    = ie_q;
    ctrl_rd[B_OV_LO +: N_CNT]    = ov_q;
    ctrl_rd[SEL0_LO +: CODE_W]   = sel_q[0];
    ctrl_rd[SEL1_LO +: CODE_W]   = sel_q[1];
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else begin
      rd_data <= '0;
      case (rd_addr)
        ADDR_CTRL: rd_data <= ctrl_rd;
        ADDR_CYC:  rd_data[CNT_W-1:0] <= cyc_val;
        ADDR_EV0:  rd_data[CNT_W-1:0] <= ev_val[0];
        default:   rd_data[CNT_W-1:0] <= ev_val[1];
      endcase
    end
  end

  logic unused_wr_bits;
  assign unused_wr_bits = &{1'b0, wr_data[31:28], wr_data[11], wr_data[7]};
endmodule

// File: rtl/perf_mon_chk.sv
module perf_mon_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             wr_en,
  input logic [1:0]       wr_addr,
  input logic [31:0]      wr_data,
  input logic [1:0]       rd_addr,
  input logic [31:0]      rd_data,
  input logic             irq,
  input logic             run_q,
  input logic [2:0]       ov_q,
  input logic [2:0]       ie_q,
  input logic [7:0]       sel0,
  input logic [CNT_W-1:0] ev0,
  input logic [CNT_W-1:0] ev1,
  input logic [CNT_W-1:0] cyc
);
  assert_gated_R2: assert property (@(posedge clk) disable iff (rst)
    (!run_q && !wr_en) |=> ($stable(ev0) && $stable(ev1) && $stable(cyc)));

  assert_idle_code_R4: assert property (@(posedge clk) disable iff (rst)
    (run_q && sel0 == 8'h20 && !wr_en) |=> $stable(ev0));

  assert_strobe_reads_zero_R6: assert property (@(posedge clk) disable iff (rst)
    (rd_addr == 2'd0) |=> (rd_data[2:1] == 2'b00));

  assert_wrap_flag_R8: assert property (@(posedge clk) disable iff (rst)
    (run_q && sel0 == 8'hFF && (&ev0) && !wr_en) |=> (ov_q[0] && ev0 == '0));

  assert_flag_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    (ov_q[2] && !(wr_en && wr_addr == 2'd0 && wr_data[10])) |=> ov_q[2]);

  assert_irq_on_R10: assert property (@(posedge clk) disable iff (rst)
    (|(ov_q & ie_q)) |=> irq);

  assert_irq_off_R10: assert property (@(posedge clk) disable iff (rst)
    !(|(ov_q & ie_q)) |=> !irq);
endmodule

bind perf_mon perf_mon_chk #(.CNT_W(CNT_W)) chk_i (
  .clk     (clk),
  .rst     (rst),
  .wr_en   (wr_en),
  .wr_addr (wr_addr),
  .wr_data (wr_data),
  .rd_addr (rd_addr),
  .rd_data (rd_data),
  .irq     (irq),
  .run_q   (run_q),
  .ov_q    (ov_q),
  .ie_q    (ie_q),
  .sel0    (sel_q[0]),
  .ev0     (ev_val[0]),
  .ev1     (ev_val[1]),
  .cyc     (cyc_val)
);

// File: tb/perf_mon_tb.sv
module perf_mon_tb_top;
  localparam int CLK_NS   = 10;
  localparam int CNT_W    = 8;
  localparam int DIV_LOG2 = 2;

  logic         clk = 1'b0;
  logic         rst;
  logic         wr_en;
  logic [1:0]   wr_addr;
  logic [31:0]  wr_data;
  logic [1:0]   rd_addr;
  logic [31:0]  rd_data;
  logic [255:0] evt_in;
  logic         irq;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_NS/2) clk = ~clk;

  perf_mon #(.CNT_W(CNT_W), .DIV_LOG2(DIV_LOG2)) dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .evt_in(evt_in), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] ctl(input bit run, input bit clr_ev, input bit clr_cyc,
                                      input bit dv, input logic [2:0] ie, input logic [2:0] ov,
                                      input logic [7:0] s0, input logic [7:0] s1);
    logic [31:0] v;
    v = '0;
    v[0] = run; v[1] = clr_ev; v[2] = clr_cyc; v[3] = dv;
    v[6:4] = ie; v[10:8] = ov; v[27:20] = s0; v[19:12] = s1;
    return v;
  endfunction

  // all tasks start and end just after a falling edge
  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    rd_addr = a;
    @(posedge clk); @(negedge clk);
    d = rd_data;
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] v, saved;
    int exp0;
    rst = 1'b1; wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0; evt_in = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      rd(a[1:0], v);
      chk("R1 reset value", v, 32'h0);
    end
    chk("R1 irq after reset", {31'b0, irq}, 32'h0);

    // R6 / R11 field readback, strobes read zero
    wr(2'd0, ctl(0, 1, 1, 1, 3'b111, 3'b000, 8'hA5, 8'h3C));
    rd(2'd0, v);
    chk("R6 R11 control readback", v, ctl(0, 0, 0, 1, 3'b111, 3'b000, 8'hA5, 8'h3C));
    wr(2'd0, 32'h0);

    // R3 / R5 sweep over selector pairs
    for (int k = 0; k < 8; k++) begin
      logic [7:0] s0, s1;
      s0 = 8'((k * 37) % 256);
      s1 = 8'(k * 29 + 1);
      wr(2'd0, ctl(1, 1, 1, 0, 3'b000, 3'b000, s0, s1));
      exp0 = 0;
      for (int i = 0; i < 10; i++) begin
        evt_in = '1;
        evt_in[s0] = ((i + k) % 3 == 0);
        evt_in[s1] = ((i % 2) == (k % 2));
        if ((i + k) % 3 == 0) exp0++;
        step();
      end
      evt_in = '0;
      wr(2'd0, ctl(0, 0, 0, 0, 3'b000, 3'b000, s0, s1));
      rd(2'd2, v); chk("R3 event counter 0 sweep", v, 32'(exp0));
      rd(2'd3, v); chk("R3 event counter 1 sweep", v, 32'd5);
      rd(2'd1, v); chk("R5 cycle count undivided", v, 32'd11);
    end

    // R4 idle code and R5 divided mode
    evt_in = '1;
    wr(2'd0, ctl(1, 1, 1, 1, 3'b000, 3'b000, 8'h20, 8'h20));
    repeat (13) step();
    wr(2'd0, ctl(0, 0, 0, 1, 3'b000, 3'b000, 8'h20, 8'h20));
    rd(2'd2, v); chk("R4 idle code holds counter 0", v, 32'd0);
    rd(2'd3, v); chk("R4 idle code holds counter 1", v, 32'd0);
    rd(2'd1, v); chk("R5 divided cycle count 14/4", v, 32'd3);
    // prescaler restarts on the cycle reset strobe
    wr(2'd0, ctl(1, 0, 1, 1, 3'b000, 3'b000, 8'h20, 8'h20));
    repeat (3) step();
    wr(2'd0, ctl(0, 0, 0, 1, 3'b000, 3'b000, 8'h20, 8'h20));
    rd(2'd1, v); chk("R5 R6 prescaler cleared by strobe", v, 32'd1);

    // R2 run clear gates everything
    wr(2'd2, 32'h15);
    wr(2'd0, ctl(0, 0, 0, 0, 3'b000, 3'b000, 8'hFF, 8'hFF));
    repeat (6) step();
    rd(2'd2, v); chk("R2 counter 0 held", v, 32'h15);
    rd(2'd3, v); chk("R2 counter 1 held", v, 32'h0);
    rd(2'd1, v); chk("R2 cycle counter held", v, 32'h1);
    evt_in = '0;

    // R7 write wins over a same-clock count, write zero clears
    wr(2'd0, ctl(1, 0, 0, 0, 3'b000, 3'b000, 8'h20, 8'hFF));
    wr(2'd3, 32'h40);
    wr(2'd0, ctl(0, 0, 0, 0, 3'b000, 3'b000, 8'h20, 8'hFF));
    rd(2'd3, v); chk("R7 write beats count", v, 32'h41);
    wr(2'd3, 32'h0);
    rd(2'd3, v); chk("R7 write zero clears", v, 32'h0);

    // R8 wrap of event counter 0
    wr(2'd2, 32'hFE);
    wr(2'd0, ctl(1, 0, 0, 0, 3'b001, 3'b000, 8'hFF, 8'h20));
    step();
    wr(2'd0, ctl(0, 0, 0, 0, 3'b001, 3'b000, 8'hFF, 8'h20));
    rd(2'd2, v); chk("R8 counter wrapped to zero", v, 32'h0);
    rd(2'd0, saved);
    chk("R8 overflow flag bit 8", saved, ctl(0, 0, 0, 0, 3'b001, 3'b001, 8'hFF, 8'h20));
    chk("R10 irq raised", {31'b0, irq}, 32'h1);

    // R9 write 0 keeps flag, write-back clears only the flag
    wr(2'd0, ctl(0, 0, 0, 0, 3'b001, 3'b000, 8'hFF, 8'h20));
    rd(2'd0, v); chk("R9 writing 0 keeps flag", v[10:8], 32'h1);
    wr(2'd0, saved);
    chk("R10 irq lags flag clear by one clock", {31'b0, irq}, 32'h1);
    step();
    chk("R10 irq drops after clear", {31'b0, irq}, 32'h0);
    rd(2'd0, v);
    chk("R9 write-back changes only flags", v, saved & ~32'h700);

    // R10 enable gating on the cycle counter flag
    wr(2'd1, 32'hFF);
    wr(2'd0, ctl(1, 0, 0, 0, 3'b000, 3'b000, 8'h20, 8'h20));
    wr(2'd0, ctl(0, 0, 0, 0, 3'b000, 3'b000, 8'h20, 8'h20));
    rd(2'd0, v); chk("R8 cycle flag bit 10", v[10:8], 32'h4);
    chk("R10 masked flag keeps irq low", {31'b0, irq}, 32'h0);
    wr(2'd0, ctl(0, 0, 0, 0, 3'b100, 3'b000, 8'h20, 8'h20));
    chk("R10 irq not yet high", {31'b0, irq}, 32'h0);
    step();
    chk("R10 irq after enable", {31'b0, irq}, 32'h1);
    wr(2'd0, ctl(0, 0, 0, 0, 3'b100, 3'b100, 8'h20, 8'h20));
    step();
    chk("R9 R10 cycle flag cleared", {31'b0, irq}, 32'h0);
    rd(2'd1, v); chk("R11 zero-extended counter read", v, 32'h0);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule